// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by fetching up to three levels of descriptors from memory: a root table, a pointer table and a page table. A request carries the logical address, a 3-bit function code, a write flag and a probe flag. The walker issues 32-bit reads on a request/acknowledge memory port, one at a time. When it finishes it raises a one-cycle `done` strobe together with the physical address and a per-request fault bit.

Two root pointers are inputs to the block: a supervisor root and a user root. Function-code bit 2 picks one of them. A 16-bit control word supplies the translation enable in bit 15 and the page-size select in bit 14. Page descriptors may point to further page descriptors, and the walker follows those links for a bounded number of hops. A sticky fault record keeps the logical address of the first faulting request until software clears it.

Probe requests run the same walk but never report a fault. This lets software look up a mapping without side effects.

Top module: `xw_walker`

## Requirements
- R1: With control bit 15 clear, an accepted request completes with `done` in the cycle after acceptance, `phys_addr` equal to the logical address, no fault and no memory read.
- R2: The first read goes to the supervisor root (function-code bit 2 = 1) or the user root (bit 2 = 0), plus logical bits 31:25 times 4.
- R3: A root descriptor whose bit 1 is clear ends the walk after one read with a fault. On every faulting walk `phys_addr` equals the logical address.
- R4: The second read goes to the root descriptor with bits 8:0 cleared, plus logical bits 24:18 times 4. A pointer descriptor whose bit 1 is clear faults after two reads.
- R5: A write faults after the second read when bit 2 is set in either the root or the pointer descriptor. A read with the same tables completes normally.
- R6: With control bit 14 clear (4 KiB pages), the third read goes to the pointer descriptor with bits 7:0 cleared, plus logical bits 17:12 times 4. The result is page-descriptor bits 31:12 joined to logical bits 11:0.
- R7: With control bit 14 set (8 KiB pages), the third read goes to the pointer descriptor with bits 6:0 cleared, plus logical bits 17:13 times 4. The result is page-descriptor bits 31:13 joined to logical bits 12:0.
- R8: A page descriptor with bits 1:0 = 2 is indirect, and the next read goes to its value with bits 1:0 cleared. Up to 4 indirect reads are followed. If the fourth indirect read again returns type 2, the walk faults.
- R9: A final page descriptor of type 0 faults. Types 1 and 3 are resident. Bit 2 set faults a write, and bit 7 set faults an access with function-code bit 2 clear.
- R10: A probe request never reports a fault and never sets the fault record. A probe with an invalid root still ends after one read.
- R11: `flt_seen` is set by the first faulting walk and `flt_addr` takes its logical address. Later faults leave `flt_addr` unchanged, and `flt_clear` clears `flt_seen`.
- R12: `req_ready` is high only while idle, and `done` lasts exactly one cycle. `mem_req` stays high with a stable `mem_addr` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_addr | input | 32 | Logical address |
| req_fc | input | 3 | Function code, bit 2 = supervisor |
| req_write | input | 1 | Access is a write |
| req_probe | input | 1 | Probe request, faults suppressed |
| ctl_word | input | 16 | Bit 15 enable, bit 14 8 KiB pages |
| sup_root | input | 32 | Supervisor root table base |
| usr_root | input | 32 | User root table base |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | One-cycle completion strobe |
| phys_addr | output | 32 | Physical address, valid with done |
| fault | output | 1 | Request faulted, valid with done |
| flt_seen | output | 1 | Sticky first-fault flag |
| flt_addr | output | 32 | Logical address of first fault |
| flt_clear | input | 1 | Clears the fault record |

## Verification
Each descriptor read takes exactly one clock edge once it is acknowledged. As a result, `done` is due in the cycle after the edge that accepted the last read, and a bypassed request shows `done` in the cycle after acceptance. The bench's memory model acknowledges every read after half a cycle. It counts the cycles from acceptance to `done` and compares that count with the number of reads the requirements predict for the case: one for an invalid root, two for a pointer fault, three plus one per indirect hop for a full walk. The fault record updates on the edge that ends the `done` cycle, so the bench samples it one cycle after `done`.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int AW = 32;
    localparam int DW = 32;

    // control word bit positions
    localparam int CTL_EN   = 15;
    localparam int CTL_PG8K = 14;

    // function-code and descriptor bit positions
    localparam int FC_SUPER = 2;
    localparam int DB_VALID = 1;
    localparam int DB_WP    = 2;
    localparam int DB_SUP   = 7;

    // low bits cleared to form table bases
    localparam int PTR_BASE_LSB  = 9;
    localparam int PG4K_BASE_LSB = 8;
    localparam int PG8K_BASE_LSB = 7;
    localparam int PG4K_OFS_W    = 12;
    localparam int PG8K_OFS_W    = 13;

    typedef enum logic [1:0] {
        PT_INVALID  = 2'd0,
        PT_RES_A    = 2'd1,
        PT_INDIRECT = 2'd2,
        PT_RES_B    = 2'd3
    } pgtype_e;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_ROOT,
        WS_PTR,
        WS_PAGE,
        WS_DONE
    } walk_st_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [2:0]    fc;
        logic          wr;
        logic          probe;
        logic          pg8k;
    } walk_req_t;

    function automatic logic [AW-1:0] word_ofs(input logic [6:0] idx);
        return {{(AW-9){1'b0}}, idx, 2'b00};
    endfunction

    function automatic logic [DW-1:0] clr_low(input logic [DW-1:0] d, input int n);
        return (d >> n) << n;
    endfunction

endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
(
    input  walk_req_t     rq,
    input  logic [AW-1:0] sup_root,
    input  logic [AW-1:0] usr_root,
    input  logic [DW-1:0] rdesc,
    input  logic [DW-1:0] pdesc,
    input  logic [DW-1:0] gdesc,
    input  logic [DW-1:0] cur,
    output logic [AW-1:0] root_fetch,
    output logic [AW-1:0] ptr_fetch,
    output logic [AW-1:0] page_fetch,
    output logic [AW-1:0] ind_fetch,
    output logic [AW-1:0] phys_res
);

    logic [AW-1:0] root_base;
    logic [AW-1:0] pg_base;
    logic [6:0]    pg_idx;
    logic          unused_lo;

    assign root_base  = rq.fc[FC_SUPER] ? sup_root : usr_root;
    assign root_fetch = root_base + word_ofs(rq.addr[31:25]);
    assign ptr_fetch  = clr_low(rdesc, PTR_BASE_LSB) + word_ofs(rq.addr[24:18]);

    always_comb begin
        if (rq.pg8k) begin
            pg_base  = clr_low(pdesc, PG8K_BASE_LSB);
            pg_idx   = {2'b00, rq.addr[17:13]};
            phys_res = {cur[AW-1:PG8K_OFS_W], rq.addr[PG8K_OFS_W-1:0]};
        end else begin
            pg_base  = clr_low(pdesc, PG4K_BASE_LSB);
            pg_idx   = {1'b0, rq.addr[17:12]};
            phys_res = {cur[AW-1:PG4K_OFS_W], rq.addr[PG4K_OFS_W-1:0]};
        end
    end

    assign page_fetch = pg_base + word_ofs(pg_idx);
    assign ind_fetch  = clr_low(gdesc, 2);

    assign unused_lo = ^{rq.fc[1:0], rq.wr, rq.probe, cur[11:0]};

endmodule

// File: rtl/xw_desc_check.sv
module xw_desc_check
    import xw_pkg::*;
(
    input  logic [7:0] cur_lo,
    input  logic       root_wp,
    input  logic       is_write,
    input  logic       is_super,
    output logic       tbl_valid,
    output logic       tbl_wp_fault,
    output logic       pg_prot_fault,
    output pgtype_e    pg_type
);

    assign tbl_valid     = cur_lo[DB_VALID];
    assign tbl_wp_fault  = is_write && (root_wp || cur_lo[DB_WP]);
    assign pg_prot_fault = (is_write && cur_lo[DB_WP]) || (cur_lo[DB_SUP] && !is_super);
    assign pg_type       = pgtype_e'(cur_lo[1:0]);

endmodule

// File: rtl/xw_fault_latch.sv
module xw_fault_latch
    import xw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          set,
    input  logic [AW-1:0] set_addr,
    input  logic          clear,
    output logic          seen,
    output logic [AW-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
            addr <= '0;
        end else if (set && (!seen || clear)) begin
            seen <= 1'b1;
            addr <= set_addr;
        end else if (clear) begin
            seen <= 1'b0;
        end
    end

    AST_FIRST_FAULT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (seen && !clear) |=> (seen && $stable(addr))); // R11

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clear && !set) |=> !seen); // R11

endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
#(
    parameter int MAX_HOPS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_fc,
    input  logic          req_write,
    input  logic          req_probe,
    input  logic [15:0]   ctl_word,
    input  logic [AW-1:0] sup_root,
    input  logic [AW-1:0] usr_root,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] phys_addr,
    output logic          fault,
    output logic          flt_seen,
    output logic [AW-1:0] flt_addr,
    input  logic          flt_clear
);

    localparam int HOP_W = $clog2(MAX_HOPS + 1);

    walk_st_e      st;
    walk_req_t     rq;
    logic [DW-1:0] rdesc, pdesc, gdesc;
    logic [HOP_W-1:0] hops;
    logic [AW-1:0] phys_q;
    logic          fault_q;

    logic [AW-1:0] root_fetch, ptr_fetch, page_fetch, ind_fetch, phys_res;
    logic          tbl_valid, tbl_wp_fault, pg_prot_fault;
    pgtype_e       pg_type;
    logic          unused_ctl;

    assign unused_ctl = ^ctl_word[13:0];

    xw_addr_gen u_addr (
        .rq         (rq),
        .sup_root   (sup_root),
        .usr_root   (usr_root),
        .rdesc      (rdesc),
        .pdesc      (pdesc),
        .gdesc      (gdesc),
        .cur        (mem_rdata),
        .root_fetch (root_fetch),
        .ptr_fetch  (ptr_fetch),
        .page_fetch (page_fetch),
        .ind_fetch  (ind_fetch),
        .phys_res   (phys_res)
    );

    xw_desc_check u_chk (
        .cur_lo        (mem_rdata[7:0]),
        .root_wp       (rdesc[DB_WP]),
        .is_write      (rq.wr),
        .is_super      (rq.fc[FC_SUPER]),
        .tbl_valid     (tbl_valid),
        .tbl_wp_fault  (tbl_wp_fault),
        .pg_prot_fault (pg_prot_fault),
        .pg_type       (pg_type)
    );

    xw_fault_latch u_flt (
        .clk      (clk),
        .rst      (rst),
        .set      (st == WS_DONE && fault_q),
        .set_addr (rq.addr),
        .clear    (flt_clear),
        .seen     (flt_seen),
        .addr     (flt_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= WS_IDLE;
            rq      <= '0;
            rdesc   <= '0;
            pdesc   <= '0;
            gdesc   <= '0;
            hops    <= '0;
            phys_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            case (st)
                WS_IDLE: begin
                    if (req_valid) begin
                        rq.addr  <= req_addr;
                        rq.fc    <= req_fc;
                        rq.wr    <= req_write;
                        rq.probe <= req_probe;
                        rq.pg8k  <= ctl_word[CTL_PG8K];
                        phys_q   <= req_addr;
                        fault_q  <= 1'b0;
                        hops     <= '0;
                        st       <= ctl_word[CTL_EN] ? WS_ROOT : WS_DONE;
                    end
                end
                WS_ROOT: begin
                    if (mem_ack) begin
                        rdesc <= mem_rdata;
                        if (!tbl_valid) begin
                            fault_q <= !rq.probe;
                            st      <= WS_DONE;
                        end else begin
                            st <= WS_PTR;
                        end
                    end
                end
                WS_PTR: begin
                    if (mem_ack) begin
                        pdesc <= mem_rdata;
                        if (!rq.probe && (tbl_wp_fault || !tbl_valid)) begin
                            fault_q <= 1'b1;
                            st      <= WS_DONE;
                        end else begin
                            st <= WS_PAGE;
                        end
                    end
                end
                WS_PAGE: begin
                    if (mem_ack) begin
                        gdesc <= mem_rdata;
                        if (pg_type == PT_INDIRECT) begin
                            if (hops == HOP_W'(MAX_HOPS)) begin
                                fault_q <= !rq.probe;
                                st      <= WS_DONE;
                            end else begin
                                hops <= hops + 1'b1;
                            end
                        end else if (pg_prot_fault && !rq.probe) begin
                            fault_q <= 1'b1;
                            st      <= WS_DONE;
                        end else if (pg_type == PT_INVALID) begin
                            fault_q <= !rq.probe;
                            st      <= WS_DONE;
                        end else begin
                            phys_q <= phys_res;
                            st     <= WS_DONE;
                        end
                    end
                end
                WS_DONE: st <= WS_IDLE;
                default: st <= WS_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st)
            WS_ROOT: mem_addr = root_fetch;
            WS_PTR:  mem_addr = ptr_fetch;
            WS_PAGE: mem_addr = (hops == '0) ? page_fetch : ind_fetch;
            default: mem_addr = '0;
        endcase
    end

    assign mem_req   = (st == WS_ROOT) || (st == WS_PTR) || (st == WS_PAGE);
    assign req_ready = (st == WS_IDLE);
    assign done      = (st == WS_DONE);
    assign phys_addr = phys_q;
    assign fault     = fault_q;

    AST_BYPASS_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !ctl_word[CTL_EN]) |=>
            (done && !mem_req && phys_addr == $past(req_addr))); // R1

    AST_FAULT_KEEPS_LOGICAL: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (phys_addr == rq.addr)); // R3

    AST_HOP_BOUND: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (hops <= HOP_W'(MAX_HOPS))); // R8

    AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (done && rq.probe) |-> !fault); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R12

endmodule

// File: tb/xw_walker_test.sv
module xw_walker_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_fc = '0;
    logic        req_write = 1'b0;
    logic        req_probe = 1'b0;
    logic [15:0] ctl_word = '0;
    logic [31:0] sup_root = 32'h0001_0000;
    logic [31:0] usr_root = 32'h0002_0000;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic [31:0] phys_addr;
    logic        fault;
    logic        flt_seen;
    logic [31:0] flt_addr;
    logic        flt_clear = 1'b0;

    int vectors = 0;
    int fails   = 0;
    int nrd     = 0;
    logic [31:0] alog [256];
    logic [31:0] mem [logic [31:0]];

    always #4 clk = ~clk;

    xw_walker uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_fc(req_fc), .req_write(req_write), .req_probe(req_probe),
        .ctl_word(ctl_word), .sup_root(sup_root), .usr_root(usr_root),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .phys_addr(phys_addr), .fault(fault),
        .flt_seen(flt_seen), .flt_addr(flt_addr), .flt_clear(flt_clear)
    );

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory model: acknowledges every read half a cycle after it appears
    always @(negedge clk) begin
        mem_ack   <= mem_req;
        mem_rdata <= mrd(mem_addr);
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            alog[nrd % 256] <= mem_addr;
            nrd <= nrd + 1;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pg_at(input logic [31:0] a, input logic [31:0] pd, input logic big);
        return big ? ((pd & ~32'h7F) + {25'd0, a[17:13], 2'b00})
                   : ((pd & ~32'hFF) + {24'd0, a[17:12], 2'b00});
    endfunction

    function automatic logic [31:0] res(input logic [31:0] a, input logic [31:0] pg, input logic big);
        return big ? ((pg & ~32'h1FFF) | (a & 32'h1FFF)) : ((pg & ~32'hFFF) | (a & 32'hFFF));
    endfunction

    task automatic build(input logic [31:0] rb, input logic [31:0] a, input logic [31:0] rd,
                         input logic [31:0] pd, input logic [31:0] gd, input logic big);
        mem.delete();
        mem[rb + {23'd0, a[31:25], 2'b00}] = rd;
        mem[(rd & ~32'h1FF) + {23'd0, a[24:18], 2'b00}] = pd;
        mem[pg_at(a, pd, big)] = gd;
    endtask

    // issues one request, checks timing, result, fault and read count
    task automatic walk(input string tag, input logic [31:0] a, input logic [2:0] fc,
                        input logic wr, input logic pr, input logic [31:0] exp_phys,
                        input logic exp_flt, input int exp_rd, output int s);
        int cyc;
        @(negedge clk);
        req_addr = a; req_fc = fc; req_write = wr; req_probe = pr; req_valid = 1'b1;
        s = nrd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, "ready low while busy (R12)", {31'd0, req_ready}, 32'd0);
        cyc = 0;
        while (!done && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
        chk(tag, "cycles to done", cyc, exp_rd);
        chk(tag, "phys", phys_addr, exp_phys);
        chk(tag, "fault", {31'd0, fault}, {31'd0, exp_flt});
        @(negedge clk);
        chk(tag, "reads", nrd - s, exp_rd);
        chk(tag, "done one cycle (R12)", {31'd0, done}, 32'd0);
    endtask

    task automatic clear_record();
        @(negedge clk); flt_clear = 1'b1;
        @(negedge clk); flt_clear = 1'b0;
    endtask

    localparam logic [31:0] A  = 32'h1234_5678;
    localparam logic [31:0] B  = 32'h8765_4321;
    localparam logic [31:0] RD = 32'h0003_01F2;
    localparam logic [31:0] P4 = 32'h0004_00F2;
    localparam logic [31:0] P8 = 32'h0004_0072;

    task automatic t_reset();
        chk("R12", "reset done", {31'd0, done}, 32'd0);
        chk("R12", "reset ready", {31'd0, req_ready}, 32'd1);
        chk("R12", "reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R11", "reset flt_seen", {31'd0, flt_seen}, 32'd0);
    endtask

    task automatic t_bypass();
        int s;
        ctl_word = 16'h0000;
        walk("R1", A, 3'd5, 1'b1, 1'b0, A, 1'b0, 0, s);
    endtask

    task automatic t_walk4k();
        int s;
        ctl_word = 16'h8000;
        build(sup_root, A, RD, P4, 32'hABCD_E001, 1'b0);
        walk("R6", A, 3'd5, 1'b0, 1'b0, res(A, 32'hABCD_E001, 1'b0), 1'b0, 3, s);
        chk("R2", "supervisor root fetch", alog[s % 256], sup_root + {23'd0, A[31:25], 2'b00});
        chk("R4", "pointer fetch", alog[(s + 1) % 256], 32'h0003_0000 + {23'd0, A[24:18], 2'b00});
        chk("R6", "page fetch", alog[(s + 2) % 256], 32'h0004_0000 + {24'd0, A[17:12], 2'b00});
    endtask

    task automatic t_user();
        int s;
        ctl_word = 16'h8000;
        build(usr_root, B, RD, P4, 32'h0BAD_F003, 1'b0);
        walk("R2", B, 3'd1, 1'b1, 1'b0, res(B, 32'h0BAD_F003, 1'b0), 1'b0, 3, s);
        chk("R2", "user root fetch", alog[s % 256], usr_root + {23'd0, B[31:25], 2'b00});
    endtask

    task automatic t_walk8k();
        int s;
        ctl_word = 16'hC000;
        build(sup_root, A, RD, P8, 32'h1357_8003, 1'b1);
        walk("R7", A, 3'd6, 1'b0, 1'b0, res(A, 32'h1357_8003, 1'b1), 1'b0, 3, s);
        chk("R7", "page fetch", alog[(s + 2) % 256], 32'h0004_0000 + {25'd0, A[17:13], 2'b00});
    endtask

    task automatic t_faults_and_record();
        int s;
        ctl_word = 16'h8000;
        clear_record();
        build(sup_root, A, 32'h0003_0000, P4, 32'h1, 1'b0);
        walk("R3", A, 3'd5, 1'b0, 1'b0, A, 1'b1, 1, s);
        chk("R11", "first fault seen", {31'd0, flt_seen}, 32'd1);
        chk("R11", "first fault addr", flt_addr, A);
        build(sup_root, B, RD, 32'h0004_0000, 32'h1, 1'b0);
        walk("R4", B, 3'd5, 1'b0, 1'b0, B, 1'b1, 2, s);
        chk("R11", "addr kept after second fault", flt_addr, A);
        clear_record();
        chk("R11", "cleared", {31'd0, flt_seen}, 32'd0);
    endtask

    task automatic t_table_wp();
        int s;
        ctl_word = 16'h8000;
        build(sup_root, A, 32'h0003_0006, P4, 32'hABCD_E001, 1'b0);
        walk("R5", A, 3'd5, 1'b1, 1'b0, A, 1'b1, 2, s);
        walk("R5", A, 3'd5, 1'b0, 1'b0, res(A, 32'hABCD_E001, 1'b0), 1'b0, 3, s);
        build(sup_root, A, RD, 32'h0004_0006, 32'hABCD_E001, 1'b0);
        walk("R5", A, 3'd5, 1'b1, 1'b0, A, 1'b1, 2, s);
    endtask

    task automatic t_page_checks();
        int s;
        ctl_word = 16'h8000;
        build(sup_root, A, RD, P4, 32'hABCD_E005, 1'b0);
        walk("R9", A, 3'd5, 1'b1, 1'b0, A, 1'b1, 3, s);
        walk("R9", A, 3'd5, 1'b0, 1'b0, res(A, 32'hABCD_E005, 1'b0), 1'b0, 3, s);
        build(usr_root, A, RD, P4, 32'hABCD_E081, 1'b0);
        walk("R9", A, 3'd1, 1'b0, 1'b0, A, 1'b1, 3, s);
        build(sup_root, A, RD, P4, 32'hABCD_E081, 1'b0);
        walk("R9", A, 3'd5, 1'b0, 1'b0, res(A, 32'hABCD_E081, 1'b0), 1'b0, 3, s);
        build(sup_root, A, RD, P4, 32'hABCD_E000, 1'b0);
        walk("R9", A, 3'd5, 1'b0, 1'b0, A, 1'b1, 3, s);
    endtask

    task automatic t_indirect();
        int s;
        ctl_word = 16'h8000;
        build(sup_root, A, RD, P4, 32'h0005_0002, 1'b0);
        mem[32'h0005_0000] = 32'h0006_0002;
        mem[32'h0006_0000] = 32'h89AB_C001;
        walk("R8", A, 3'd5, 1'b0, 1'b0, res(A, 32'h89AB_C001, 1'b0), 1'b0, 5, s);
        chk("R8", "indirect fetch", alog[(s + 3) % 256], 32'h0005_0000);
        build(sup_root, A, RD, P4, 32'h0005_0002, 1'b0);
        for (int k = 0; k < 3; k++)
            mem[32'h0005_0000 + 32'(k * 16)] = 32'h0005_0012 + 32'(k * 16);
        mem[32'h0005_0030] = 32'h89AB_C003;
        walk("R8", A, 3'd5, 1'b0, 1'b0, res(A, 32'h89AB_C003, 1'b0), 1'b0, 7, s);
        mem[32'h0005_0030] = 32'h0005_0042;
        walk("R8", A, 3'd5, 1'b0, 1'b0, A, 1'b1, 7, s);
    endtask

    task automatic t_probe();
        int s;
        ctl_word = 16'h8000;
        clear_record();
        build(sup_root, A, 32'h0003_0000, P4, 32'h1, 1'b0);
        walk("R10", A, 3'd5, 1'b0, 1'b1, A, 1'b0, 1, s);
        build(sup_root, A, RD, P4, 32'hABCD_E005, 1'b0);
        walk("R10", A, 3'd5, 1'b1, 1'b1, res(A, 32'hABCD_E005, 1'b0), 1'b0, 3, s);
        chk("R10", "record untouched", {31'd0, flt_seen}, 32'd0);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_walk4k();
        t_user();
        t_walk8k();
        t_faults_and_record();
        t_table_wp();
        t_page_checks();
        t_indirect();
        t_probe();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule